// File: doc/BRIEF.md
# Addressable RGB LED String Driver

This block streams a frame of 24-bit colours from a synchronous dual-port RAM to a chain of self-clocked RGB LEDs over one serial wire. It repeats the frame without end. The processor side writes the RAM. Word 0 holds the number of pixels. Words 1 to N hold one colour each. The driver reads the count, sends each pixel's 24 bits with the most significant bit first, holds the line low long enough for the chain to latch, and then starts over by reading the count again. The count is reread for every frame, so software can change the frame length between frames.

Each bit occupies a fixed window of `TICKS` clock cycles. The default is 25 cycles, which is 1.25 µs at 20 MHz. A shift register is preloaded with one of two constant high/low patterns: a long high time for a one and a short high time for a zero. Its top bit drives the line. The next pixel word is fetched while the current pixel's last bit is still being sent, so bits follow each other with no gap, including across pixel boundaries. The RAM has one cycle of read latency. Each address is issued one cycle before the data is captured.

The sequencer state machine has six states. `ST_CNT_ADDR` presents address 0 and always moves to `ST_CNT_CAPT`. `ST_CNT_CAPT` captures the count. It goes to `ST_LATCH` when the count is zero and to `ST_PIX_ADDR` otherwise. `ST_PIX_ADDR` presents address 1 and moves to `ST_PIX_CAPT`. `ST_PIX_CAPT` captures the first pixel, loads its first bit pattern and moves to `ST_SEND`. `ST_SEND` reloads the shifter at the last tick of every bit. After the final bit of the final pixel it goes to `ST_LATCH`. `ST_LATCH` waits out the gap timer and then returns to `ST_CNT_ADDR`.

Top module: `ledstr_driver`

## Requirements
- R1: During and right after a synchronous reset, `led_out` is 0 and `ram_addr` is 0. After reset is released, the first read is address 0. A reset in the middle of a frame restarts the frame from the count read.
- R2: When the low `ADDR_W` bits of word 0 are zero, no pulse appears on `led_out`, and `ram_addr` stays 0 through the gap and the repeated count reads.
- R3: Pixel words are read from consecutive addresses 1, 2, …, N, where N is the count. `ram_addr` only ever steps up by one or returns to 0, and it never exceeds N.
- R4: Each pixel word is sent as exactly 24 bit windows, bit 23 first and bit 0 last. Pixels are sent in address order, and exactly N×24 bits make up a frame.
- R5: A one bit is `ONE_HIGH` (16) cycles high followed by `TICKS-ONE_HIGH` (9) cycles low. A zero bit is `ZERO_HIGH` (8) cycles high followed by `TICKS-ZERO_HIGH` (17) cycles low.
- R6: Within a frame, consecutive rising edges of `led_out` are exactly `TICKS` (25) cycles apart, including across pixel boundaries.
- R7: After the last bit of a frame, `led_out` stays low for at least `LATCH_CYCLES` (1000) cycles before the next frame's first rising edge.
- R8: After the gap, the driver rereads address 0 and sends the frame again. Two successive frames from unchanged RAM are identical.
- R9: The pixel count is taken from bits `[ADDR_W-1:0]` of word 0. Higher bits of that word are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock; one cycle is one pattern tick |
| rst | input | 1 | Synchronous reset, active high |
| ram_addr | output | ADDR_W | Read address to the RAM |
| ram_rdata | input | COLOR_W | RAM read data, valid one cycle after the address |
| led_out | output | 1 | Serial line to the LED chain |

## Verification
The hardest case to reach from the ports is the pixel-boundary handover. There, the next word must arrive by prefetch during the last bit of the previous pixel, without stretching that bit. It is reached by frames of two and three pixels whose neighbouring words differ sharply: all ones next to all zeros, and a word with set end bits next to mixed words. A decoder measures every high width and every rise-to-rise period. Unused RAM words beyond the count are filled with nonzero junk, and the count word carries set upper bits, so an over-read or a wide count decode shows up as extra bits. A reset pulse in the middle of a frame checks that the restart is clean.

// File: rtl/ledstr_pkg.sv
package ledstr_pkg;

    typedef enum logic [2:0] {
        ST_CNT_ADDR,
        ST_CNT_CAPT,
        ST_PIX_ADDR,
        ST_PIX_CAPT,
        ST_SEND,
        ST_LATCH
    } seq_state_t;

endpackage

// File: rtl/ledstr_pattern_shifter.sv
module ledstr_pattern_shifter #(
    parameter int TICKS     = 25,
    parameter int ONE_HIGH  = 16,
    parameter int ZERO_HIGH = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic bit_val,
    output logic led_out,
    output logic last_tick
);
    localparam int TW = $clog2(TICKS);
    localparam logic [TICKS-1:0] ALL_ONES = '1;
    localparam logic [TICKS-1:0] PAT_ONE  = ALL_ONES << (TICKS - ONE_HIGH);
    localparam logic [TICKS-1:0] PAT_ZERO = ALL_ONES << (TICKS - ZERO_HIGH);

    logic [TICKS-1:0] sreg;
    logic [TW-1:0]    tick;
    logic             busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg <= '0;
            tick <= '0;
            busy <= 1'b0;
        end else if (load) begin
            sreg <= bit_val ? PAT_ONE : PAT_ZERO;
            tick <= '0;
            busy <= 1'b1;
        end else if (busy) begin
            sreg <= sreg << 1;
            if (tick == TW'(TICKS - 1)) begin
                busy <= 1'b0;
            end else begin
                tick <= tick + 1'b1;
            end
        end
    end

    assign led_out   = sreg[TICKS-1];
    assign last_tick = busy && (tick == TW'(TICKS - 1));

    // R6: a new pattern only starts when the previous window has ended
    assert_load_period_R6: assert property (@(posedge clk) disable iff (rst)
        load |-> (!busy || last_tick));

    // R5: the line falls only after one of the two legal high widths
    assert_high_width_R5: assert property (@(posedge clk) disable iff (rst)
        (busy && $fell(led_out)) |-> (tick == TW'(ONE_HIGH) || tick == TW'(ZERO_HIGH)));

endmodule

// File: rtl/ledstr_gap_timer.sv
module ledstr_gap_timer #(
    parameter int CYCLES = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic done
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt;
    logic          run;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            run <= 1'b0;
        end else if (start) begin
            cnt <= CW'(CYCLES - 1);
            run <= 1'b1;
        end else if (run) begin
            if (cnt == '0) begin
                run <= 1'b0;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    assign done = run && (cnt == '0);

endmodule

// File: rtl/ledstr_sequencer.sv
module ledstr_sequencer
    import ledstr_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter int COLOR_W = 24
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [COLOR_W-1:0] rd_data,
    input  logic               last_tick,
    input  logic               gap_done,
    input  logic               led_level,
    output logic [ADDR_W-1:0]  ram_addr,
    output logic               load,
    output logic               bit_val,
    output logic               gap_start
);
    localparam int BW = $clog2(COLOR_W);

    seq_state_t         state;
    seq_state_t         nxt;
    logic [ADDR_W-1:0]  count;
    logic [COLOR_W-1:0] word;
    logic [BW-1:0]      bit_idx;
    logic               more;
    logic               fetch1;
    logic               fetch2;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_CNT_ADDR;
        end else begin
            state <= nxt;
        end
    end

    // next state and outputs
    always_comb begin
        nxt       = state;
        load      = 1'b0;
        bit_val   = 1'b0;
        gap_start = 1'b0;
        unique case (state)
            ST_CNT_ADDR: nxt = ST_CNT_CAPT;
            ST_CNT_CAPT: begin
                if (rd_data[ADDR_W-1:0] == '0) begin
                    nxt       = ST_LATCH;
                    gap_start = 1'b1;
                end else begin
                    nxt = ST_PIX_ADDR;
                end
            end
            ST_PIX_ADDR: nxt = ST_PIX_CAPT;
            ST_PIX_CAPT: begin
                load    = 1'b1;
                bit_val = rd_data[COLOR_W-1];
                nxt     = ST_SEND;
            end
            ST_SEND: begin
                if (last_tick) begin
                    if (bit_idx != '0) begin
                        load    = 1'b1;
                        bit_val = word[bit_idx - 1'b1];
                    end else if (more) begin
                        load    = 1'b1;
                        bit_val = word[COLOR_W-1];
                    end else begin
                        nxt       = ST_LATCH;
                        gap_start = 1'b1;
                    end
                end
            end
            ST_LATCH: begin
                if (gap_done) begin
                    nxt = ST_CNT_ADDR;
                end
            end
            default: nxt = ST_CNT_ADDR;
        endcase
    end

    // address, count, pixel word and bit index
    always_ff @(posedge clk) begin
        if (rst) begin
            ram_addr <= '0;
            count    <= '0;
            word     <= '0;
            bit_idx  <= '0;
            more     <= 1'b0;
            fetch1   <= 1'b0;
            fetch2   <= 1'b0;
        end else begin
            fetch1 <= 1'b0;
            fetch2 <= fetch1;
            if (fetch2) begin
                word <= rd_data;
            end
            case (state)
                ST_CNT_CAPT: begin
                    count <= rd_data[ADDR_W-1:0];
                    if (rd_data[ADDR_W-1:0] != '0) begin
                        ram_addr <= ADDR_W'(1);
                    end
                end
                ST_PIX_CAPT: begin
                    word    <= rd_data;
                    bit_idx <= BW'(COLOR_W - 1);
                end
                ST_SEND: begin
                    if (last_tick) begin
                        if (bit_idx != '0) begin
                            bit_idx <= bit_idx - 1'b1;
                            if (bit_idx == BW'(1)) begin
                                if (ram_addr != count) begin
                                    ram_addr <= ram_addr + 1'b1;
                                    more     <= 1'b1;
                                    fetch1   <= 1'b1;
                                end else begin
                                    more <= 1'b0;
                                end
                            end
                        end else if (more) begin
                            bit_idx <= BW'(COLOR_W - 1);
                            more    <= 1'b0;
                        end else begin
                            ram_addr <= '0;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // R1: the first cycle out of reset reads the count word
    assert_reset_start_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (state == ST_CNT_ADDR && ram_addr == '0 && !led_level));

    // R3: pixel reads never pass the captured count
    assert_addr_bound_R3: assert property (@(posedge clk) disable iff (rst)
        (state != ST_CNT_ADDR && state != ST_CNT_CAPT) |-> (ram_addr <= count));

    // R3: the address only steps by one or goes back to zero
    assert_addr_step_R3: assert property (@(posedge clk) disable iff (rst)
        !$stable(ram_addr) |-> (ram_addr == '0 || ram_addr == ADDR_W'($past(ram_addr) + 1'b1)));

    // R2: a zero count goes straight to the gap
    assert_zero_skip_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CNT_CAPT && rd_data[ADDR_W-1:0] == '0) |=> (state == ST_LATCH));

    // R7: the line is low for the whole gap
    assert_latch_low_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LATCH) |-> !led_level);

    // R8: after the gap the count word is read again
    assert_reread_R8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LATCH && gap_done) |=> (state == ST_CNT_ADDR && ram_addr == '0));

endmodule

// File: rtl/ledstr_driver.sv
module ledstr_driver #(
    parameter int ADDR_W       = 10,
    parameter int COLOR_W      = 24,
    parameter int TICKS        = 25,
    parameter int ONE_HIGH     = 16,
    parameter int ZERO_HIGH    = 8,
    parameter int LATCH_CYCLES = 1000
) (
    input  logic               clk,
    input  logic               rst,
    output logic [ADDR_W-1:0]  ram_addr,
    input  logic [COLOR_W-1:0] ram_rdata,
    output logic               led_out
);
    logic load;
    logic bit_val;
    logic last_tick;
    logic gap_start;
    logic gap_done;

    ledstr_sequencer #(
        .ADDR_W (ADDR_W),
        .COLOR_W(COLOR_W)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .rd_data  (ram_rdata),
        .last_tick(last_tick),
        .gap_done (gap_done),
        .led_level(led_out),
        .ram_addr (ram_addr),
        .load     (load),
        .bit_val  (bit_val),
        .gap_start(gap_start)
    );

    ledstr_pattern_shifter #(
        .TICKS    (TICKS),
        .ONE_HIGH (ONE_HIGH),
        .ZERO_HIGH(ZERO_HIGH)
    ) u_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .bit_val  (bit_val),
        .led_out  (led_out),
        .last_tick(last_tick)
    );

    ledstr_gap_timer #(
        .CYCLES(LATCH_CYCLES)
    ) u_gap (
        .clk  (clk),
        .rst  (rst),
        .start(gap_start),
        .done (gap_done)
    );

endmodule

// File: tb/tb_ledstr_driver.sv
module tb_ledstr_driver;
    localparam int ADDR_W    = 10;
    localparam int COLOR_W   = 24;
    localparam int TICKS     = 25;
    localparam int ONE_HIGH  = 16;
    localparam int ZERO_HIGH = 8;
    localparam int LATCH     = 1000;
    localparam int FRAME_END = 200;
    localparam int NV        = 4;

    localparam logic [23:0] CW_T [NV] = '{24'h000001, 24'h000002, 24'hABC003, 24'h000001};
    localparam logic [23:0] PX_T [NV][3] = '{
        '{24'hA53C0F, 24'h000000, 24'h000000},
        '{24'hFFFFFF, 24'h000000, 24'h000000},
        '{24'h800001, 24'h123456, 24'hFEDCBA},
        '{24'h000001, 24'h000000, 24'h000000}
    };

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [ADDR_W-1:0]  ram_addr;
    logic [COLOR_W-1:0] ram_rdata;
    logic               led_out;
    logic [23:0]        mem [0:15];

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    ledstr_driver #(
        .ADDR_W(ADDR_W), .COLOR_W(COLOR_W), .TICKS(TICKS),
        .ONE_HIGH(ONE_HIGH), .ZERO_HIGH(ZERO_HIGH), .LATCH_CYCLES(LATCH)
    ) dut (
        .clk(clk), .rst(rst), .ram_addr(ram_addr),
        .ram_rdata(ram_rdata), .led_out(led_out)
    );

    always_ff @(posedge clk) ram_rdata <= mem[ram_addr[3:0]];

    // line decoder
    logic prev = 1'b0;
    int hi_cnt = 0, since_rise = 0, low_run = 100000, nbits = 0;
    int frames = 0, rises = 0, bad_hi = 0, bad_period = 0;
    int last_gap = 0, run_max = 0, done_max = 0;
    bit fbits [0:127];

    always @(negedge clk) begin
        if (rst) begin
            prev = 1'b0; hi_cnt = 0; low_run = 100000; since_rise = 0;
            run_max = 0; nbits = 0;
        end else begin
            if (int'(ram_addr) > run_max) run_max = int'(ram_addr);
            if (led_out) begin
                if (!prev) begin
                    rises++;
                    if (low_run >= FRAME_END) begin
                        last_gap = low_run;
                        nbits = 0;
                    end else if (since_rise != TICKS) begin
                        bad_period++;
                    end
                    since_rise = 0;
                end
                hi_cnt++;
                low_run = 0;
            end else begin
                if (prev) begin
                    if (hi_cnt == ONE_HIGH || hi_cnt == ZERO_HIGH) begin
                        if (nbits < 128) fbits[nbits] = (hi_cnt == ONE_HIGH);
                        nbits++;
                    end else begin
                        bad_hi++;
                    end
                    hi_cnt = 0;
                end
                low_run++;
                if (low_run == FRAME_END && nbits > 0) begin
                    frames++;
                    done_max = run_max;
                    run_max = 0;
                end
            end
            since_rise++;
            prev = led_out;
        end
    end

    task automatic check_int(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_frames(input int target);
        int guard;
        guard = 0;
        while (frames < target && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        check_int("R8 frame arrives (1=yes)", int'(frames >= target), 1);
    endtask

    task automatic check_frame(input int v, input string tag);
        int cnt, bad, first;
        cnt = int'(CW_T[v][ADDR_W-1:0]);
        check_int({tag, " R4 R9 bit count"}, nbits, cnt * 24);
        bad = 0; first = -1;
        for (int p = 0; p < cnt; p++) begin
            for (int b = 23; b >= 0; b--) begin
                int idx;
                idx = p * 24 + (23 - b);
                if (idx < 128 && fbits[idx] != PX_T[v][p][b]) begin
                    bad++;
                    if (first < 0) first = idx;
                end
            end
        end
        check_int({tag, " R4 R5 mismatching bits"}, bad, 0);
        if (bad != 0) $display("  first mismatch at bit index %0d", first);
    endtask

    initial begin
        int bh, bp, r0;
        for (int i = 0; i < 16; i++) mem[i] = 24'hC3C3C3;

        // R1: reset state
        repeat (3) @(negedge clk);
        check_int("R1 led_out in reset", int'(led_out), 0);
        check_int("R1 ram_addr in reset", int'(ram_addr), 0);

        // vector table walked by one loop
        for (int v = 0; v < NV; v++) begin
            int base;
            for (int i = 0; i < 16; i++) mem[i] = 24'hC3C3C3;
            mem[0] = CW_T[v];
            for (int p = 0; p < int'(CW_T[v][ADDR_W-1:0]); p++) mem[p + 1] = PX_T[v][p];
            do_reset();
            @(negedge clk);
            check_int("R1 first address after reset", int'(ram_addr), 0);
            base = frames; bh = bad_hi; bp = bad_period;
            wait_frames(base + 1);
            check_frame(v, "frame1");
            check_int("R5 bad high widths", bad_hi - bh, 0);
            check_int("R6 bad bit periods", bad_period - bp, 0);
            check_int("R3 highest address", done_max, int'(CW_T[v][ADDR_W-1:0]));
            wait_frames(base + 2);
            check_frame(v, "frame2 R8");
            check_int("R7 gap at least latch time (1=yes)", int'(last_gap >= LATCH), 1);
            check_int("R6 bad bit periods frame2", bad_period - bp, 0);
        end

        // R2 R9: zero count with upper bits set in word 0
        for (int i = 0; i < 16; i++) mem[i] = 24'hC3C3C3;
        mem[0] = 24'h000400;
        do_reset();
        r0 = rises;
        repeat (3000) @(negedge clk);
        check_int("R2 R9 pulses with zero count", rises - r0, 0);
        check_int("R2 highest address with zero count", run_max, 0);
        check_int("R2 line low", int'(led_out), 0);

        // R1: reset in the middle of a frame, then clean restart
        mem[0] = CW_T[2];
        for (int p = 0; p < 3; p++) mem[p + 1] = PX_T[2][p];
        do_reset();
        repeat (500) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check_int("R1 led_out after mid-frame reset", int'(led_out), 0);
        check_int("R1 ram_addr after mid-frame reset", int'(ram_addr), 0);
        rst = 1'b0;
        begin
            int base;
            base = frames; bh = bad_hi; bp = bad_period;
            wait_frames(base + 1);
            check_frame(2, "restart R1");
            check_int("R5 restart high widths", bad_hi - bh, 0);
            check_int("R6 restart periods", bad_period - bp, 0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 20);
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors + 1);
        $finish;
    end

endmodule